// File: doc/BRIEF.md
# Transfer Recording Qualifier

This block sits beside the retirement stage of a processor that keeps a history of control transfers. For every retiring transfer it decides whether a history entry is to be written and, for records that cross a privilege boundary, whether the source or the destination address in that entry must be blanked. The decision draws on the enabled privilege levels, a per-type filter word, the level-crossing rules for traps and trap returns, opt-in enables for traps that leave the enabled levels, and the debug state.

The block also holds the frozen status bit. While this bit is set nothing is recorded. Hardware sets it when a counter-overflow interrupt or a breakpoint exception traps to a supervisor or machine level with the matching freeze enable set. Software can set or clear it through a write port, and a hardware freeze wins over a software write in the same cycle. Each decision appears on registered outputs one clock after the transfer is presented.

Top module: `xfer_rec_qual`

## Requirements
- R1: Privilege levels are encoded U=2'b00, S=2'b01, M=2'b11, and 2'b10 is treated as disabled. `lvl_en` bit 0 enables U, bit 1 enables S and bit 2 enables M. A transfer that is not a trap or a trap return is recorded when `xfer_vld` is high, its source level is enabled, its type passes the filter and the frozen bit is clear. In that case `rec_stb` is high in the cycle after the transfer with both zero flags low. With `xfer_vld` low, nothing is recorded.
- R2: Type codes are: 1 exception, 2 interrupt, 3 trap return, 4 not-taken branch, 5 taken branch, 8 to 15 jump classes. Codes 0, 6 and 7 are never recorded. Filter bit k inhibits type k, except bit 4, which must be set for not-taken branches to be recorded. With a zero filter word, every type except not-taken branches passes.
- R3: A trap (type 1 or 2) between two enabled levels is recorded without zeroing, subject to filter bit 1 or bit 2.
- R4: A trap from a disabled level into an enabled level is recorded with `zero_src_pc` high, subject to the filter.
- R5: A trap from an enabled level into a disabled level is recorded only when the external-trap enables of the target level and of every level in between are set: U to S needs `ext_en[0]`, S to M needs `ext_en[1]`, and U to M needs both. Such a record has `zero_dst_pc` high and ignores the filter bits.
- R6: A trap return between enabled levels is recorded normally. A return from an enabled level to a disabled level is recorded with `zero_dst_pc` high. A return out of a disabled level is never recorded. Filter bit 3 applies to trap returns.
- R7: A transfer whose source or destination is Debug Mode is never recorded.
- R8: An interrupt with cause 13 and `frz_ovf_en` set, or an exception with cause 3 and `frz_brk_en` set, that traps to S or M sets `frozen` in the next cycle. Such a trap is not recorded.
- R9: While `frozen` is high, no transfer is recorded.
- R10: `sw_frz_we` loads `sw_frz_val` into `frozen` in the next cycle. A hardware freeze in the same cycle takes priority.
- R11: After reset, `frozen`, `rec_stb` and both zero flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_vld | input | 1 | A control transfer retires this cycle |
| xfer_type | input | 4 | Transfer type code |
| src_lvl | input | 2 | Privilege level before the transfer |
| dst_lvl | input | 2 | Privilege level after the transfer |
| src_dbg | input | 1 | Transfer starts in Debug Mode |
| dst_dbg | input | 1 | Transfer ends in Debug Mode |
| trap_cause | input | 6 | Cause code of a trap |
| lvl_en | input | 3 | Record enables for U, S, M |
| ext_en | input | 2 | External-trap enables for S (bit 0) and M (bit 1) |
| type_filt | input | 16 | Type filter word |
| frz_ovf_en | input | 1 | Freeze on counter-overflow interrupt |
| frz_brk_en | input | 1 | Freeze on breakpoint exception |
| sw_frz_we | input | 1 | Software write of the frozen bit |
| sw_frz_val | input | 1 | Value written by software |
| rec_stb | output | 1 | Record the transfer |
| zero_src_pc | output | 1 | Blank the source address in the record |
| zero_dst_pc | output | 1 | Blank the destination address in the record |
| frozen | output | 1 | Frozen status |

## Verification
A hardware freeze event and a software write of the frozen bit can land in the same cycle. The bench provokes this by presenting a counter-overflow interrupt trap to S while it writes 0 through the software port. It then expects `frozen` to read 1 in the next cycle and no record to be made. A second collision pairs an ordinary transfer with a software write of 1. That transfer must still be recorded, because the decision uses the frozen bit as it stood before the write took effect.

// File: rtl/xrq_pkg.sv
package xrq_pkg;
    localparam int LVL_W   = 2;
    localparam int TYPE_W  = 4;
    localparam int NTYPES  = 1 << TYPE_W;
    localparam int CAUSE_W = 6;

    localparam logic [LVL_W-1:0] LVL_U = 2'b00;
    localparam logic [LVL_W-1:0] LVL_S = 2'b01;
    localparam logic [LVL_W-1:0] LVL_M = 2'b11;

    localparam logic [TYPE_W-1:0] T_EXC  = 4'd1;
    localparam logic [TYPE_W-1:0] T_INT  = 4'd2;
    localparam logic [TYPE_W-1:0] T_RET  = 4'd3;
    localparam logic [TYPE_W-1:0] T_NTBR = 4'd4;

    typedef struct packed {
        logic rec;
        logic zsrc;
        logic zdst;
    } verdict_t;
endpackage

// File: rtl/xrq_lvl_lookup.sv
module xrq_lvl_lookup
    import xrq_pkg::*;
(
    input  logic [LVL_W-1:0] lvl,
    input  logic [2:0]       lvl_en,
    output logic             en
);
    always_comb begin
        unique case (lvl)
            LVL_U:   en = lvl_en[0];
            LVL_S:   en = lvl_en[1];
            LVL_M:   en = lvl_en[2];
            default: en = 1'b0;
        endcase
    end
endmodule

// File: rtl/xrq_type_filter.sv
module xrq_type_filter
    import xrq_pkg::*;
(
    input  logic [TYPE_W-1:0] xtype,
    input  logic [NTYPES-1:0] filt,
    output logic              pass
);
    logic [NTYPES-1:0] pass_vec;

    for (genvar k = 0; k < NTYPES; k++) begin : g_bit
        if (k == 0 || k == 6 || k == 7) begin : g_unused
            assign pass_vec[k] = 1'b0;
        end else if (k == 4) begin : g_optin
            assign pass_vec[k] = filt[k];
        end else begin : g_inhibit
            assign pass_vec[k] = ~filt[k];
        end
    end

    assign pass = pass_vec[xtype];
endmodule

// File: rtl/xrq_freeze.sv
module xrq_freeze (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_set,
    input  logic sw_we,
    input  logic sw_val,
    output logic frozen_q
);
    logic frozen_d;

    always_comb begin
        frozen_d = frozen_q;
        if (sw_we)  frozen_d = sw_val;
        if (hw_set) frozen_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) frozen_q <= 1'b0;
        else        frozen_q <= frozen_d;
    end

    assert_hw_over_sw_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set && sw_we && !sw_val) |=> frozen_q);
    assert_sw_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_set && sw_we) |=> (frozen_q == $past(sw_val)));
endmodule

// File: rtl/xfer_rec_qual.sv
module xfer_rec_qual
    import xrq_pkg::*;
#(
    parameter logic [CAUSE_W-1:0] OVF_CAUSE = 6'd13,
    parameter logic [CAUSE_W-1:0] BRK_CAUSE = 6'd3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               xfer_vld,
    input  logic [TYPE_W-1:0]  xfer_type,
    input  logic [LVL_W-1:0]   src_lvl,
    input  logic [LVL_W-1:0]   dst_lvl,
    input  logic               src_dbg,
    input  logic               dst_dbg,
    input  logic [CAUSE_W-1:0] trap_cause,
    input  logic [2:0]         lvl_en,
    input  logic [1:0]         ext_en,
    input  logic [NTYPES-1:0]  type_filt,
    input  logic               frz_ovf_en,
    input  logic               frz_brk_en,
    input  logic               sw_frz_we,
    input  logic               sw_frz_val,
    output logic               rec_stb,
    output logic               zero_src_pc,
    output logic               zero_dst_pc,
    output logic               frozen
);
    logic src_en, dst_en, type_ok, ext_ok, frz_evt, is_trap, dst_high;
    verdict_t v_d, v_q;

    xrq_lvl_lookup u_src (.lvl(src_lvl), .lvl_en(lvl_en), .en(src_en));
    xrq_lvl_lookup u_dst (.lvl(dst_lvl), .lvl_en(lvl_en), .en(dst_en));
    xrq_type_filter u_filt (.xtype(xfer_type), .filt(type_filt), .pass(type_ok));

    assign is_trap  = (xfer_type == T_EXC) || (xfer_type == T_INT);
    assign dst_high = (dst_lvl == LVL_S) || (dst_lvl == LVL_M);

    // Freeze events: overflow interrupt or breakpoint exception trapping upward.
    always_comb begin
        frz_evt = 1'b0;
        if (xfer_vld && !src_dbg && !dst_dbg && dst_high) begin
            if (xfer_type == T_INT && trap_cause == OVF_CAUSE && frz_ovf_en) frz_evt = 1'b1;
            if (xfer_type == T_EXC && trap_cause == BRK_CAUSE && frz_brk_en) frz_evt = 1'b1;
        end
    end

    // External-trap opt-in: target level and every level in between.
    always_comb begin
        ext_ok = 1'b0;
        if (src_lvl == LVL_U && dst_lvl == LVL_S) ext_ok = ext_en[0];
        if (src_lvl == LVL_U && dst_lvl == LVL_M) ext_ok = ext_en[0] && ext_en[1];
        if (src_lvl == LVL_S && dst_lvl == LVL_M) ext_ok = ext_en[1];
    end

    xrq_freeze u_frz (
        .clk(clk), .rst_n(rst_n), .hw_set(frz_evt),
        .sw_we(sw_frz_we), .sw_val(sw_frz_val), .frozen_q(frozen)
    );

    always_comb begin
        v_d = '0;
        if (xfer_vld && !frozen && !src_dbg && !dst_dbg && !frz_evt) begin
            if (is_trap) begin
                unique case ({src_en, dst_en})
                    2'b11: v_d.rec = type_ok;
                    2'b01: begin v_d.rec = type_ok; v_d.zsrc = type_ok; end
                    2'b10: begin v_d.rec = ext_ok;  v_d.zdst = ext_ok;  end
                    default: v_d = '0;
                endcase
            end else if (xfer_type == T_RET) begin
                unique case ({src_en, dst_en})
                    2'b11: v_d.rec = type_ok;
                    2'b10: begin v_d.rec = type_ok; v_d.zdst = type_ok; end
                    default: v_d = '0;
                endcase
            end else begin
                v_d.rec = src_en && type_ok;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v_q <= '0;
        else        v_q <= v_d;
    end

    assign rec_stb     = v_q.rec;
    assign zero_src_pc = v_q.zsrc;
    assign zero_dst_pc = v_q.zdst;

    assert_idle_no_rec_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_vld |=> !rec_stb);
    assert_ntbr_optin_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_type == T_NTBR && !type_filt[4]) |=> !rec_stb);
    assert_zero_implies_rec_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_src_pc || zero_dst_pc) |-> rec_stb);
    assert_ret_disabled_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_type == T_RET && !src_en) |=> !rec_stb);
    assert_debug_never_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (src_dbg || dst_dbg) |=> !rec_stb);
    assert_freeze_trap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_vld && xfer_type == T_INT && trap_cause == OVF_CAUSE && frz_ovf_en
         && dst_high && !src_dbg && !dst_dbg) |=> (frozen && !rec_stb));
    assert_frozen_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |=> !rec_stb);
endmodule

// File: tb/tb_xfer_rec_qual.sv
module tb_xfer_rec_qual;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xfer_vld = 1'b0;
    logic [3:0] xfer_type = '0;
    logic [1:0] src_lvl = '0, dst_lvl = '0;
    logic src_dbg = 1'b0, dst_dbg = 1'b0;
    logic [5:0] trap_cause = '0;
    logic [2:0] lvl_en = 3'b111;
    logic [1:0] ext_en = 2'b00;
    logic [15:0] type_filt = '0;
    logic frz_ovf_en = 1'b0, frz_brk_en = 1'b0;
    logic sw_frz_we = 1'b0, sw_frz_val = 1'b0;
    logic rec_stb, zero_src_pc, zero_dst_pc, frozen;

    int n_checks = 0;
    int n_errs = 0;
    bit done = 1'b0;

    localparam logic [1:0] U = 2'b00, S = 2'b01, M = 2'b11;

    always #10 clk = ~clk;

    xfer_rec_qual dut (.*);

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: got rec/zs/zd/frz=%b expected %b", tag, act, exp);
        end
    endtask

    // Present one transfer, then sample the registered verdict.
    task automatic xfer(input string tag, input logic [3:0] t, input logic [1:0] s,
                        input logic [1:0] d, input logic [5:0] c,
                        input logic er, input logic ezs, input logic ezd, input logic efz);
        @(negedge clk);
        xfer_vld = 1'b1; xfer_type = t; src_lvl = s; dst_lvl = d; trap_cause = c;
        @(posedge clk); #1;
        xfer_vld = 1'b0;
        chk(tag, {rec_stb, zero_src_pc, zero_dst_pc, frozen}, {er, ezs, ezd, efz});
    endtask

    task automatic sw_write(input logic val);
        @(negedge clk);
        sw_frz_we = 1'b1; sw_frz_val = val;
        @(posedge clk); #1;
        sw_frz_we = 1'b0;
    endtask

    task automatic t_reset();
        #1 chk("R11 reset", {rec_stb, zero_src_pc, zero_dst_pc, frozen}, 4'b0000);
    endtask

    task automatic t_basic();
        lvl_en = 3'b111; type_filt = '0;
        xfer("R1 taken branch in U", 4'd5, U, U, 6'd0, 1, 0, 0, 0);
        lvl_en = 3'b110;
        xfer("R1 branch in disabled U", 4'd5, U, U, 6'd0, 0, 0, 0, 0);
        lvl_en = 3'b111;
        @(negedge clk); xfer_type = 4'd5;
        @(posedge clk); #1;
        chk("R1 no valid", {rec_stb, zero_src_pc, zero_dst_pc, frozen}, 4'b0000);
    endtask

    task automatic t_filter();
        lvl_en = 3'b111; type_filt = '0;
        xfer("R2 not-taken default", 4'd4, S, S, 6'd0, 0, 0, 0, 0);
        type_filt = 16'h0010;
        xfer("R2 not-taken opt-in", 4'd4, S, S, 6'd0, 1, 0, 0, 0);
        type_filt = 16'h0200;
        xfer("R2 direct call inhibited", 4'd9, S, S, 6'd0, 0, 0, 0, 0);
        xfer("R2 indirect call passes", 4'd8, S, S, 6'd0, 1, 0, 0, 0);
        type_filt = '0;
        xfer("R2 reserved code 6", 4'd6, S, S, 6'd0, 0, 0, 0, 0);
    endtask

    task automatic t_traps();
        lvl_en = 3'b111; type_filt = '0;
        xfer("R3 exc U->S enabled", 4'd1, U, S, 6'd2, 1, 0, 0, 0);
        type_filt = 16'h0002;
        xfer("R3 exc inhibited", 4'd1, U, S, 6'd2, 0, 0, 0, 0);
        type_filt = '0; lvl_en = 3'b010;
        xfer("R4 int from disabled U", 4'd2, U, S, 6'd5, 1, 1, 0, 0);
        lvl_en = 3'b001; ext_en = 2'b01;
        xfer("R5 ext U->S", 4'd1, U, S, 6'd2, 1, 0, 1, 0);
        xfer("R5 ext U->M needs M too", 4'd1, U, M, 6'd2, 0, 0, 0, 0);
        ext_en = 2'b11; type_filt = 16'h0006;
        xfer("R5 ext U->M ignores filter", 4'd1, U, M, 6'd2, 1, 0, 1, 0);
        type_filt = '0; lvl_en = 3'b010; ext_en = 2'b10;
        xfer("R5 ext S->M", 4'd2, S, M, 6'd7, 1, 0, 1, 0);
        ext_en = 2'b01;
        xfer("R5 ext S->M no M enable", 4'd2, S, M, 6'd7, 0, 0, 0, 0);
        ext_en = 2'b00;
    endtask

    task automatic t_returns();
        type_filt = '0; lvl_en = 3'b011;
        xfer("R6 ret S->U enabled", 4'd3, S, U, 6'd0, 1, 0, 0, 0);
        lvl_en = 3'b010;
        xfer("R6 ret into disabled", 4'd3, S, U, 6'd0, 1, 0, 1, 0);
        lvl_en = 3'b001;
        xfer("R6 ret out of disabled", 4'd3, S, U, 6'd0, 0, 0, 0, 0);
    endtask

    task automatic t_debug();
        lvl_en = 3'b111;
        src_dbg = 1'b1;
        xfer("R7 out of debug", 4'd3, M, M, 6'd0, 0, 0, 0, 0);
        src_dbg = 1'b0; dst_dbg = 1'b1;
        xfer("R7 into debug", 4'd1, M, M, 6'd3, 0, 0, 0, 0);
        dst_dbg = 1'b0;
    endtask

    task automatic t_freeze();
        lvl_en = 3'b111; type_filt = '0; frz_ovf_en = 1'b1;
        xfer("R8 overflow int freezes", 4'd2, U, S, 6'd13, 0, 0, 0, 1);
        xfer("R9 frozen blocks branch", 4'd5, U, U, 6'd0, 0, 0, 0, 1);
        sw_write(1'b0);
        chk("R10 sw clear", {3'b000, frozen}, 4'b0000);
        frz_ovf_en = 1'b0;
        xfer("R8 brk without enable", 4'd1, U, M, 6'd3, 1, 0, 0, 0);
        frz_brk_en = 1'b1;
        xfer("R8 brk freezes", 4'd1, U, M, 6'd3, 0, 0, 0, 1);
        frz_brk_en = 1'b0;
        sw_write(1'b0);
        sw_write(1'b1);
        chk("R10 sw set", {3'b000, frozen}, 4'b0001);
        sw_write(1'b0);
        // Collision: hardware freeze and software clear together.
        frz_ovf_en = 1'b1;
        @(negedge clk);
        sw_frz_we = 1'b1; sw_frz_val = 1'b0;
        xfer_vld = 1'b1; xfer_type = 4'd2; src_lvl = U; dst_lvl = S; trap_cause = 6'd13;
        @(posedge clk); #1;
        xfer_vld = 1'b0; sw_frz_we = 1'b0;
        chk("R10 hw freeze wins", {rec_stb, zero_src_pc, zero_dst_pc, frozen}, 4'b0001);
        frz_ovf_en = 1'b0;
        sw_write(1'b0);
        // Software set alongside a branch: branch uses the old frozen value.
        @(negedge clk);
        sw_frz_we = 1'b1; sw_frz_val = 1'b1;
        xfer_vld = 1'b1; xfer_type = 4'd5; src_lvl = U; dst_lvl = U;
        @(posedge clk); #1;
        xfer_vld = 1'b0; sw_frz_we = 1'b0;
        chk("R10 write with branch", {rec_stb, zero_src_pc, zero_dst_pc, frozen}, 4'b1001);
        sw_write(1'b0);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_checks++; n_errs++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_basic();
        t_filter();
        t_traps();
        t_returns();
        t_debug();
        t_freeze();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule